// File: doc/BRIEF.md
# Mesh Router Input Port with Virtual Channels

This block is one input port of a wormhole router in a two-dimensional mesh. Flits come in from one neighbour, or from the local endpoint, through a valid/ready handshake. Each flit is tagged with a virtual channel number, and each virtual channel has its own flit FIFO and its own ready line. At the head of each FIFO the port works out the output direction of the packet. For a head flit it compares the destination coordinates in the flit with the coordinates of this node, using dimension-order routing. The order is X first or Y first, chosen by a parameter. The port then locks that direction for every later flit of the packet, until the last flit leaves.

The port presents one flit at a time to the crossbar, together with its virtual channel and direction. The crossbar takes it by raising `out_ready`. The highest-priority non-empty virtual channel always wins. A lower channel that is cut off in the middle of a packet keeps its locked route and carries on once the higher traffic has gone. A packet whose route would send it back out of the direction it arrived from is never presented. Each of its flits is removed from the FIFO instead.

Each lane runs a two-state machine. `LANE_IDLE` means the next flit is a head, and its route is computed fresh. `LANE_LOCKED` means a packet is in flight on that lane. The lane takes the LOCK transition from `LANE_IDLE` to `LANE_LOCKED` when a head flit that does not end its packet leaves. It takes the RELEASE transition from `LANE_LOCKED` back to `LANE_IDLE` when the last flit leaves. A lane stays in `LANE_IDLE` when a one-flit packet leaves.

Top module: `router_in_port`

## Requirements
- R1: After reset every bit of `in_ready` is 1 and `out_valid` is 0.
- R2: Flit bit fields, with default widths:
  - [31:30] is the flit type: 2'b11 single-flit packet, 2'b01 head, 2'b00 body, 2'b10 tail.
  - In a head flit, [29:28] is the destination X and [27:26] is the destination Y.
  - [25:22] is the length field, equal to the number of flits minus one.
- R3: With X-first routing (`XY_FIRST`=1), the direction is chosen as follows. Destination X greater than the node's X gives `out_dir`=1 (east), and less gives 2 (west). Otherwise destination Y greater gives 3 (north), and less gives 4 (south). Equal in both gives 0 (local).
- R4: With `XY_FIRST`=0 the Y comparison is made first, using the same direction codes.
- R5: A flit accepted at a clock edge into an empty lane appears on `out_flit` with `out_valid`=1 after that edge, whatever the value of `out_ready`.
- R6: The body and tail flits of a packet leave with the direction of their head flit, whatever their bit contents.
- R7: A packet ends at one of four flits:
  - a single-flit type flit;
  - a head flit whose length field is 0;
  - a tail-type flit;
  - the flit whose count after the head reaches the length field.
  The next flit on that lane is then routed as a head.
- R8: A packet whose route equals the arrival direction `IN_DIR` is discarded without `out_valid`, and its flits leave the FIFO.
- R9: When a lane holds `FIFO_DEPTH` flits, its `in_ready` bit is 0 and a flit offered to it is not taken. Other lanes keep `in_ready`=1.
- R10: When more than one lane holds a flit, the one presented is the lowest-numbered lane if `VC0_HIGH`=1, and the highest-numbered lane otherwise.
- R11: A lane preempted in the middle of a packet resumes later with its locked route, and its flits stay in order.
- R12: While `out_ready` is 0 and no higher lane fills, the presented flit stays on the outputs and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| here_x | input | X_W | X coordinate of this node |
| here_y | input | Y_W | Y coordinate of this node |
| in_valid | input | 1 | Upstream flit valid |
| in_vc | input | VCW | Virtual channel of the incoming flit |
| in_flit | input | FLIT_W | Incoming flit |
| in_ready | output | NUM_VC | Per-lane ready (FIFO not full) |
| out_valid | output | 1 | A flit is presented to the crossbar |
| out_vc | output | VCW | Lane of the presented flit |
| out_flit | output | FLIT_W | Presented flit |
| out_dir | output | 3 | Output direction code of the presented flit |
| out_ready | input | 1 | Crossbar takes the presented flit |

## Verification
If a lane is left in the wrong state, the damage shows within one packet. A lane stuck in `LANE_LOCKED` gives the next head flit the old direction, and the monitor catches that on the first flit that leaves. A lane released too early routes a body flit as if it were a head. Body flits carry random bits, so the result is a wrong `out_dir` or a dropped flit, and the next comparison or the final drain check reports it. A wrong length counter or a wrong priority choice shows up as flits leaving in the wrong order. The directed preemption test checks that order one flit at a time.

// File: rtl/noc_port_pkg.sv
package noc_port_pkg;

    typedef enum logic [2:0] {
        DIR_LOCAL = 3'd0,
        DIR_EAST  = 3'd1,
        DIR_WEST  = 3'd2,
        DIR_NORTH = 3'd3,
        DIR_SOUTH = 3'd4
    } dir_e;

    typedef enum logic [1:0] {
        FT_BODY   = 2'b00,
        FT_HEAD   = 2'b01,
        FT_TAIL   = 2'b10,
        FT_SINGLE = 2'b11
    } ftype_e;

    typedef enum logic {
        LANE_IDLE   = 1'b0,
        LANE_LOCKED = 1'b1
    } lane_state_e;

endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         not_empty,
    output logic         not_full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;

    assign not_empty = (count != '0);
    assign not_full  = (count != (AW+1)'(DEPTH));
    assign head_data = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/route_calc.sv
module route_calc
    import noc_port_pkg::*;
#(
    parameter int X_W      = 2,
    parameter int Y_W      = 2,
    parameter bit XY_FIRST = 1'b1
) (
    input  logic [X_W-1:0] here_x,
    input  logic [Y_W-1:0] here_y,
    input  logic [X_W-1:0] dest_x,
    input  logic [Y_W-1:0] dest_y,
    output dir_e           dir
);
    dir_e x_dir, y_dir;

    always_comb begin
        if (dest_x > here_x)      x_dir = DIR_EAST;
        else if (dest_x < here_x) x_dir = DIR_WEST;
        else                      x_dir = DIR_LOCAL;
        if (dest_y > here_y)      y_dir = DIR_NORTH;
        else if (dest_y < here_y) y_dir = DIR_SOUTH;
        else                      y_dir = DIR_LOCAL;
    end

    generate
        if (XY_FIRST) begin : g_xy
            assign dir = (x_dir != DIR_LOCAL) ? x_dir : y_dir;
        end else begin : g_yx
            assign dir = (y_dir != DIR_LOCAL) ? y_dir : x_dir;
        end
    endgenerate
endmodule

// File: rtl/vc_lane.sv
module vc_lane
    import noc_port_pkg::*;
#(
    parameter int FLIT_W   = 32,
    parameter int DEPTH    = 2,
    parameter int X_W      = 2,
    parameter int Y_W      = 2,
    parameter int LEN_W    = 4,
    parameter bit XY_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [X_W-1:0]    here_x,
    input  logic [Y_W-1:0]    here_y,
    input  logic              push,
    input  logic [FLIT_W-1:0] push_flit,
    input  logic              pop,
    output logic              ready,
    output logic              valid,
    output logic [FLIT_W-1:0] flit,
    output dir_e              dir
);
    localparam int T_HI = FLIT_W - 1;
    localparam int X_HI = FLIT_W - 3;
    localparam int X_LO = X_HI - X_W + 1;
    localparam int Y_HI = X_LO - 1;
    localparam int Y_LO = Y_HI - Y_W + 1;
    localparam int L_HI = Y_LO - 1;
    localparam int L_LO = L_HI - LEN_W + 1;

    lane_state_e      st, st_nxt;
    dir_e             lock_dir, dir_nxt, fresh_dir;
    logic [LEN_W-1:0] remain, rem_nxt;
    ftype_e           ftype;
    logic [LEN_W-1:0] pkt_len;
    logic             is_last;

    flit_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_flit),
        .pop(pop), .head_data(flit),
        .not_empty(valid), .not_full(ready)
    );

    route_calc #(.X_W(X_W), .Y_W(Y_W), .XY_FIRST(XY_FIRST)) u_route (
        .here_x(here_x), .here_y(here_y),
        .dest_x(flit[X_HI:X_LO]), .dest_y(flit[Y_HI:Y_LO]),
        .dir(fresh_dir)
    );

    assign ftype   = ftype_e'(flit[T_HI -: 2]);
    assign pkt_len = flit[L_HI:L_LO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= LANE_IDLE;
            lock_dir <= DIR_LOCAL;
            remain   <= '0;
        end else begin
            st       <= st_nxt;
            lock_dir <= dir_nxt;
            remain   <= rem_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        dir_nxt = lock_dir;
        rem_nxt = remain;
        dir     = lock_dir;
        is_last = 1'b0;
        unique case (st)
            LANE_IDLE: begin
                dir     = fresh_dir;
                is_last = (ftype == FT_SINGLE) || (ftype == FT_TAIL) || (pkt_len == '0);
                if (pop && !is_last) begin
                    st_nxt  = LANE_LOCKED;
                    dir_nxt = fresh_dir;
                    rem_nxt = pkt_len;
                end
            end
            LANE_LOCKED: begin
                is_last = (ftype == FT_TAIL) || (remain == LEN_W'(1));
                if (pop) begin
                    if (is_last) st_nxt = LANE_IDLE;
                    else         rem_nxt = remain - 1'b1;
                end
            end
            default: st_nxt = LANE_IDLE;
        endcase
    end
endmodule

// File: rtl/router_in_port.sv
module router_in_port
    import noc_port_pkg::*;
#(
    parameter int NUM_VC     = 2,
    parameter int FIFO_DEPTH = 2,
    parameter int FLIT_W     = 32,
    parameter int X_W        = 2,
    parameter int Y_W        = 2,
    parameter int LEN_W      = 4,
    parameter bit XY_FIRST   = 1'b1,
    parameter bit VC0_HIGH   = 1'b1,
    parameter int IN_DIR     = 2,
    localparam int VCW       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [X_W-1:0]    here_x,
    input  logic [Y_W-1:0]    here_y,
    input  logic              in_valid,
    input  logic [VCW-1:0]    in_vc,
    input  logic [FLIT_W-1:0] in_flit,
    output logic [NUM_VC-1:0] in_ready,
    output logic              out_valid,
    output logic [VCW-1:0]    out_vc,
    output logic [FLIT_W-1:0] out_flit,
    output logic [2:0]        out_dir,
    input  logic              out_ready
);
    localparam dir_e ARRIVAL = dir_e'(IN_DIR);

    logic [NUM_VC-1:0] lane_valid, lane_pop, lane_push;
    logic [FLIT_W-1:0] lane_flit [NUM_VC];
    dir_e              lane_dir  [NUM_VC];
    logic [VCW-1:0]    sel;
    logic              any_valid, uturn;

    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_lane
            assign lane_push[v] = in_valid && (in_vc == VCW'(v)) && in_ready[v];
            assign lane_pop[v]  = any_valid && (sel == VCW'(v)) && (out_ready || uturn);
            vc_lane #(
                .FLIT_W(FLIT_W), .DEPTH(FIFO_DEPTH), .X_W(X_W), .Y_W(Y_W),
                .LEN_W(LEN_W), .XY_FIRST(XY_FIRST)
            ) u_lane (
                .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
                .push(lane_push[v]), .push_flit(in_flit), .pop(lane_pop[v]),
                .ready(in_ready[v]), .valid(lane_valid[v]),
                .flit(lane_flit[v]), .dir(lane_dir[v])
            );
        end
    endgenerate

    // Later iterations override earlier ones, so the last one scanned is the highest priority.
    always_comb begin
        sel       = '0;
        any_valid = 1'b0;
        for (int i = 0; i < NUM_VC; i++) begin
            int v;
            v = VC0_HIGH ? (NUM_VC - 1 - i) : i;
            if (lane_valid[v]) begin
                sel       = VCW'(v);
                any_valid = 1'b1;
            end
        end
    end

    assign uturn     = (lane_dir[sel] == ARRIVAL);
    assign out_valid = any_valid && !uturn;
    assign out_vc    = sel;
    assign out_flit  = lane_flit[sel];
    assign out_dir   = lane_dir[sel];
endmodule

// File: rtl/router_in_port_checks.sv
module router_in_port_checks #(
    parameter int NUM_VC   = 2,
    parameter bit VC0_HIGH = 1'b1,
    parameter int IN_DIR   = 2,
    parameter int VCW      = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [VCW-1:0]    out_vc,
    input logic [2:0]        out_dir,
    input logic [NUM_VC-1:0] in_ready,
    input logic [NUM_VC-1:0] lane_valid
);
    localparam int HI = VC0_HIGH ? 0 : NUM_VC - 1;

    // R8
    no_uturn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dir != 3'(IN_DIR)));

    // R10
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && lane_valid[HI]) |-> (out_vc == VCW'(HI)));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> lane_valid[$past(out_vc)]);

    // R9
    full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~in_ready) & (~lane_valid)) == '0);
endmodule

bind router_in_port router_in_port_checks #(
    .NUM_VC(NUM_VC), .VC0_HIGH(VC0_HIGH), .IN_DIR(IN_DIR), .VCW(VCW)
) u_checks (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_vc(out_vc), .out_dir(out_dir), .in_ready(in_ready), .lane_valid(lane_valid)
);

// File: tb/tb_router_in_port.sv
module tb_router_in_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    localparam int ARR = 2;

    logic [1:0]  here_x = 2'd1, here_y = 2'd1;
    logic        in_valid = 1'b0, in_vc = 1'b0;
    logic [31:0] in_flit = '0;
    logic [1:0]  in_ready;
    logic        out_valid, out_vc, out_ready = 1'b0;
    logic [31:0] out_flit;
    logic [2:0]  out_dir;

    logic        y_valid = 1'b0;
    logic [31:0] y_flit = '0;
    logic [1:0]  y_ready;
    logic        y_ov, y_ovc;
    logic [31:0] y_of;
    logic [2:0]  y_odir;

    router_in_port dut (
        .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
        .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit), .in_ready(in_ready),
        .out_valid(out_valid), .out_vc(out_vc), .out_flit(out_flit),
        .out_dir(out_dir), .out_ready(out_ready)
    );

    router_in_port #(.XY_FIRST(1'b0), .IN_DIR(0)) dut_yx (
        .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
        .in_valid(y_valid), .in_vc(1'b0), .in_flit(y_flit), .in_ready(y_ready),
        .out_valid(y_ov), .out_vc(y_ovc), .out_flit(y_of),
        .out_dir(y_odir), .out_ready(1'b1)
    );

    int n_chk = 0, n_fail = 0;
    logic [34:0] q0[$], q1[$];
    int trace[$];
    bit rand_rdy = 1'b0, force_rdy = 1'b0;
    logic [34:0] mon_e;

    task automatic check(bit ok, string req, string what, logic [34:0] act, logic [34:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int ref_route(int dx, int dy, bit xy);
        int xd, yd;
        xd = (dx > 1) ? 1 : (dx < 1) ? 2 : 0;
        yd = (dy > 1) ? 3 : (dy < 1) ? 4 : 0;
        if (xy) return (xd != 0) ? xd : yd;
        return (yd != 0) ? yd : xd;
    endfunction

    function automatic logic [31:0] mk(int ft, int dx, int dy, int len, logic [21:0] msg);
        return {2'(ft), 2'(dx), 2'(dy), 4'(len), msg};
    endfunction

    function automatic void expect_flit(int vc, int dir, logic [31:0] f);
        if (vc == 0) q0.push_back({3'(dir), f});
        else         q1.push_back({3'(dir), f});
    endfunction

    always @(posedge clk) begin
        #2;
        out_ready = rand_rdy ? ($urandom_range(3) != 0) : force_rdy;
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            trace.push_back(int'(out_vc));
            if ((out_vc == 1'b0) ? (q0.size() == 0) : (q1.size() == 0)) begin
                check(1'b0, "R8", "unexpected flit", {out_dir, out_flit}, '0);
            end else begin
                mon_e = (out_vc == 1'b0) ? q0.pop_front() : q1.pop_front();
                check({out_dir, out_flit} == mon_e, "R3/R6/R7", "flit and route", {out_dir, out_flit}, mon_e);
            end
        end
    end

    task automatic send_flit(int vc, logic [31:0] f);
        @(negedge clk);
        in_valid = 1'b1; in_vc = vc[0]; in_flit = f;
        while (in_ready[vc] !== 1'b1) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic send_pkt(int vc, int dx, int dy, int len, bit use_tail);
        int dir, ft;
        logic [31:0] f;
        dir = ref_route(dx, dy, 1'b1);
        ft = (len == 0) ? (($urandom_range(1) != 0) ? 3 : 1) : 1;
        f = mk(ft, dx, dy, len, 22'($urandom));
        if (dir != ARR) expect_flit(vc, dir, f);
        send_flit(vc, f);
        for (int i = 1; i <= len; i++) begin
            f = $urandom;
            f[31:30] = (i == len && use_tail) ? 2'b10 : 2'b00;
            if (dir != ARR) expect_flit(vc, dir, f);
            send_flit(vc, f);
        end
    endtask

    task automatic drain(string req);
        force_rdy = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (q0.size() == 0 && q1.size() == 0 && !out_valid) break;
        end
        check(q0.size() == 0 && q1.size() == 0, req, "all expected flits delivered",
              35'(q0.size() + q1.size()), '0);
    endtask

    task automatic send_yx(int dx, int dy, int exp_dir, bit exp_valid);
        @(negedge clk);
        y_valid = 1'b1; y_flit = mk(3, dx, dy, 0, 22'h1234);
        @(posedge clk);
        #1 y_valid = 1'b0;
        @(negedge clk);
        check(y_ov == exp_valid, exp_valid ? "R4" : "R8", "yx valid", 35'(y_ov), 35'(exp_valid));
        if (exp_valid) check(int'(y_odir) == exp_dir, "R4", "yx route", 35'(y_odir), 35'(exp_dir));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] f, h1;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(in_ready == 2'b11, "R1", "in_ready after reset", 35'(in_ready), 35'h3);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 35'(out_valid), 35'h0);

        // R5 and R3: one-cycle presentation, north route
        force_rdy = 1'b0;
        repeat (2) @(negedge clk);
        f = mk(3, 1, 3, 0, 22'h2aaaa);
        expect_flit(0, 3, f);
        in_valid = 1'b1; in_vc = 1'b0; in_flit = f;
        check(out_valid == 1'b0, "R5", "not yet valid", 35'(out_valid), 35'h0);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R5", "valid after one edge", 35'(out_valid), 35'h1);
        check(out_dir == 3'd3 && out_flit == f, "R2/R3", "north head", {out_dir, out_flit}, {3'd3, f});
        drain("R5");

        // R9 and R12: fill lane 1, offer more, hold
        force_rdy = 1'b0;
        repeat (2) @(negedge clk);
        h1 = mk(1, 3, 1, 1, 22'h11);
        expect_flit(1, 1, h1);
        send_flit(1, h1);
        f = mk(0, 0, 0, 0, 22'h22);
        expect_flit(1, 1, f);
        send_flit(1, f);
        @(negedge clk);
        check(in_ready == 2'b01, "R9", "lane 1 full, lane 0 free", 35'(in_ready), 35'h1);
        in_valid = 1'b1; in_vc = 1'b1; in_flit = 32'hdeadbeef;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        check(in_ready[1] == 1'b0, "R9", "still full", 35'(in_ready), 35'h1);
        check(out_valid && out_flit == h1, "R12", "presented flit held", {2'b0, out_valid, out_flit}, {3'b001, h1});
        drain("R9");

        // R10, R11, R6: preempt lane 1 mid-packet
        force_rdy = 1'b0;
        repeat (2) @(negedge clk);
        h1 = mk(1, 3, 0, 2, 22'h33);
        expect_flit(1, 1, h1);
        send_flit(1, h1);
        trace.delete();
        force_rdy = 1'b1;
        while (trace.size() == 0) @(negedge clk);
        force_rdy = 1'b0;
        repeat (2) @(negedge clk);
        f = mk(1, 1, 0, 1, 22'h44); expect_flit(0, 4, f); send_flit(0, f);
        f = mk(2, 0, 0, 0, 22'h55); expect_flit(0, 4, f); send_flit(0, f);
        f = mk(0, 0, 2, 0, 22'h66); expect_flit(1, 1, f); send_flit(1, f);
        f = mk(0, 0, 1, 0, 22'h77); expect_flit(1, 1, f); send_flit(1, f);
        @(negedge clk);
        check(out_vc == 1'b0, "R10", "higher lane presented", 35'(out_vc), 35'h0);
        drain("R11");
        check(trace.size() == 5, "R11", "flit count", 35'(trace.size()), 35'd5);
        if (trace.size() == 5) begin
            check(trace[0] == 1 && trace[1] == 0 && trace[2] == 0 && trace[3] == 1 && trace[4] == 1,
                  "R10/R11", "lane order", 35'({trace[0][0], trace[1][0], trace[2][0], trace[3][0], trace[4][0]}), 35'b10011);
        end

        // R8: U-turn packets are discarded
        force_rdy = 1'b0;
        repeat (2) @(negedge clk);
        send_flit(0, mk(3, 0, 1, 0, 22'h88));
        send_flit(0, mk(1, 0, 2, 2, 22'h99));
        send_flit(0, mk(0, 1, 1, 0, 22'h1));
        send_flit(0, mk(0, 2, 2, 0, 22'h2));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "no U-turn output", 35'(out_valid), 35'h0);
        check(in_ready == 2'b11, "R8", "dropped flits removed", 35'(in_ready), 35'h3);
        f = mk(3, 1, 1, 0, 22'h3); expect_flit(0, 0, f); send_flit(0, f);
        drain("R8");

        // R4: Y-first instance
        send_yx(3, 3, 3, 1'b1);
        send_yx(0, 0, 4, 1'b1);
        send_yx(2, 1, 1, 1'b1);
        send_yx(1, 1, 0, 1'b0);

        // Random traffic (R3, R6, R7, R8)
        force_rdy = 1'b0;
        rand_rdy = 1'b1;
        for (int p = 0; p < 80; p++) begin
            send_pkt($urandom_range(1), $urandom_range(3), $urandom_range(3),
                     $urandom_range(3), $urandom_range(1) != 0);
        end
        rand_rdy = 1'b0;
        drain("R7");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule